// File: doc/BRIEF.md
# Dual-Channel Integration Sequencer

This block sets the timing of a light-to-count conversion in which two channels integrate over the same window. Each channel delivers a count-enable pulse stream. The block sets the window length in one of two ways: it counts clock cycles for a preset period, or it follows a manual start and stop. At the end of a window it moves both channel totals into the result registers in the same clock edge, sends a one-cycle end-of-conversion pulse, and opens the next window at once.

Software-side control reaches the block through two byte-wide write ports with read-back. One port holds the power state. The other is a timing byte that holds the period code, the manual start/stop bit and the gain select bit. The gain select bit is only passed to an output for the analog stage; it does not change the counting. Each channel counter accepts at most one pulse every two cycles. A 2-count offset is taken off each total and the result saturates at the top of the result width.

Top module: `dual_integ_seq`

## Requirements
- R1: After reset the block is powered down, the power byte reads 00h, the timing byte reads 02h, both results are 0, and `eoc`, `busy` and `gain_hi` are low.
- R2: Writing 03h to the power byte powers the block up and writing 00h powers it down. The power byte reads back bits [1:0] of the last value written, with bits [7:2] reading 0.
- R3: Timing bits [1:0] select a preset window of UNIT×11 cycles (00), UNIT×81 cycles (01) or UNIT×322 cycles (10). In a preset mode, successive `eoc` pulses are exactly one window apart, because each new window starts with no idle cycle.
- R4: A channel accepts at most one pulse in any two consecutive cycles. A pulse input held high through a window of L cycles therefore gives L/2 − 2.
- R5: A channel whose window holds N accepted pulses reports N − 2, or 0 when N < 2.
- R6: A result saturates at 2^CNT_W − 1.
- R7: Both results change only in the cycle where `eoc` is high. `eoc` lasts one cycle, and both results come from the same window.
- R8: A new period code written during a window does not change that window. It takes effect from the next window.
- R9: With code 11, setting timing bit 3 to 1 starts a window and clearing it ends the window, which transfers the results. While bit 3 is 0, no window runs and no `eoc` occurs, and a manual window has no time limit.
- R10: Timing bit 3 has no effect for codes 00, 01 and 10.
- R11: While powered down, no window runs, `eoc` stays low and the results keep their values. Powering up starts a fresh window.
- R12: Timing bit 4 drives `gain_hi` and has no effect on the counts. The timing byte reads back bits 4, 3, 1 and 0 as written, with the other bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_wr | input | 1 | Power byte write strobe |
| pwr_wdata | input | 8 | Power byte write value |
| pwr_rdata | output | 8 | Power byte read-back |
| tim_wr | input | 1 | Timing byte write strobe |
| tim_wdata | input | 8 | Timing byte write value |
| tim_rdata | output | 8 | Timing byte read-back |
| ch0_pulse | input | 1 | Channel 0 count-enable pulse |
| ch1_pulse | input | 1 | Channel 1 count-enable pulse |
| data0 | output | CNT_W | Channel 0 result |
| data1 | output | CNT_W | Channel 1 result |
| eoc | output | 1 | One-cycle end-of-conversion pulse |
| gain_hi | output | 1 | High-gain select for the analog stage |
| powered_up | output | 1 | Block is powered up |
| busy | output | 1 | A window is in progress |

## Verification
A wrong window counter shows up as a wrong spacing between `eoc` pulses, and this can be seen one window after the fault. A wrong count, offset or saturation shows up in the result registers at the next `eoc`. If a counter is not cleared between windows, the error carries into the following result, so back-to-back bursts of differing length expose it within two windows. A wrong power or manual state shows up at once as `busy`, or as an `eoc` in a stretch where none may occur.

// File: rtl/dual_integ_seq_pkg.sv
package dual_integ_seq_pkg;
   typedef enum logic [1:0] {SQ_OFF, SQ_WAIT, SQ_PRESET, SQ_MANUAL} sq_state_t;
   localparam logic [1:0] CODE_MANUAL = 2'b11;
   localparam logic [1:0] PWR_ON      = 2'b11;
   localparam logic [7:0] TIM_RESET   = 8'h02;
   localparam int         TIM_GAIN_BIT = 4;
   localparam int         TIM_MAN_BIT  = 3;
endpackage

// File: rtl/dual_integ_seq_cfg.sv
module dual_integ_seq_cfg
   import dual_integ_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwr_wr,
   input  logic [7:0] pwr_wdata,
   input  logic       tim_wr,
   input  logic [7:0] tim_wdata,
   output logic [1:0] pwr_bits,
   output logic [1:0] integ_code,
   output logic       manual_bit,
   output logic       gain_bit,
   output logic [7:0] pwr_rdata,
   output logic [7:0] tim_rdata
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pwr_bits   <= 2'b00;
         integ_code <= TIM_RESET[1:0];
         manual_bit <= TIM_RESET[TIM_MAN_BIT];
         gain_bit   <= TIM_RESET[TIM_GAIN_BIT];
      end else begin
         if (pwr_wr) pwr_bits <= pwr_wdata[1:0];
         if (tim_wr) begin
            integ_code <= tim_wdata[1:0];
            manual_bit <= tim_wdata[TIM_MAN_BIT];
            gain_bit   <= tim_wdata[TIM_GAIN_BIT];
         end
      end
   end

   always_comb begin
      pwr_rdata = {6'b0, pwr_bits};
      tim_rdata = 8'h00;
      tim_rdata[1:0]          = integ_code;
      tim_rdata[TIM_MAN_BIT]  = manual_bit;
      tim_rdata[TIM_GAIN_BIT] = gain_bit;
   end
endmodule

// File: rtl/dual_integ_seq_ctl.sv
module dual_integ_seq_ctl
   import dual_integ_seq_pkg::*;
#(
   parameter int UNIT  = 918,
   parameter int MULT0 = 11,
   parameter int MULT1 = 81,
   parameter int MULT2 = 322
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       powered,
   input  logic [1:0] integ_code,
   input  logic       manual_bit,
   output logic       count_en,
   output logic       restart,
   output logic       xfer,
   output logic       busy
);
   localparam int LEN0  = UNIT * MULT0;
   localparam int LEN1  = UNIT * MULT1;
   localparam int LEN2  = UNIT * MULT2;
   localparam int CYC_W = $clog2(LEN2);

   if (UNIT < 1 || MULT0 < 1 || MULT0 >= MULT1 || MULT1 >= MULT2) begin : g_bad_mult
      $error("dual_integ_seq_ctl: multipliers must be positive and strictly increasing");
   end
   if (LEN0 < 4) begin : g_bad_len
      $error("dual_integ_seq_ctl: shortest window must be at least 4 cycles");
   end

   function automatic logic [CYC_W-1:0] last_of(input logic [1:0] code);
      case (code)
         2'b00:   last_of = CYC_W'(LEN0 - 1);
         2'b01:   last_of = CYC_W'(LEN1 - 1);
         default: last_of = CYC_W'(LEN2 - 1);
      endcase
   endfunction

   sq_state_t        state, state_nxt;
   logic [CYC_W-1:0] cyc;
   logic [CYC_W-1:0] last_idx;
   logic             at_last, man_stop, decide, go_preset;

   always_comb begin
      busy      = (state == SQ_PRESET) || (state == SQ_MANUAL);
      at_last   = (state == SQ_PRESET) && (cyc == last_idx);
      man_stop  = (state == SQ_MANUAL) && !((integ_code == CODE_MANUAL) && manual_bit);
      xfer      = powered && (at_last || man_stop);
      decide    = (state == SQ_OFF) || (state == SQ_WAIT) || xfer;
      count_en  = powered && busy;
      restart   = !powered || decide;
      go_preset = powered && decide && (integ_code != CODE_MANUAL);
      state_nxt = state;
      if (!powered)                          state_nxt = SQ_OFF;
      else if (decide) begin
         if (integ_code != CODE_MANUAL)      state_nxt = SQ_PRESET;
         else if (manual_bit)                state_nxt = SQ_MANUAL;
         else                                state_nxt = SQ_WAIT;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= SQ_OFF;
         cyc      <= '0;
         last_idx <= '0;
      end else begin
         state <= state_nxt;
         if (go_preset) begin
            cyc      <= '0;
            last_idx <= last_of(integ_code);
         end else if (state == SQ_PRESET) begin
            cyc <= cyc + 1'b1;
         end
      end
   end
endmodule

// File: rtl/dual_integ_seq_chan.sv
module dual_integ_seq_chan #(
   parameter int CNT_W   = 16,
   parameter int OFFSET  = 2,
   parameter bit HOLDOFF = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             en,
   input  logic             pulse,
   output logic [CNT_W-1:0] folded
);
   localparam int RAW_W   = CNT_W + 1;
   localparam int MAXV    = (2 ** CNT_W) - 1;
   localparam int RAW_CAP = MAXV + OFFSET;

   if (OFFSET < 0 || OFFSET >= MAXV) begin : g_bad_off
      $error("dual_integ_seq_chan: offset out of range");
   end

   logic [RAW_W-1:0] raw, raw_nxt;
   logic             hold, accept;

   if (HOLDOFF) begin : g_rate_limited
      assign accept = en && pulse && !hold;
   end else begin : g_every_cycle
      assign accept = en && pulse;
   end

   always_comb begin
      raw_nxt = raw;
      if (accept && (raw != RAW_W'(RAW_CAP))) raw_nxt = raw + 1'b1;
      if (raw_nxt >= RAW_W'(RAW_CAP))       folded = CNT_W'(MAXV);
      else if (raw_nxt >= RAW_W'(OFFSET))   folded = CNT_W'(raw_nxt - RAW_W'(OFFSET));
      else                                  folded = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         raw  <= '0;
         hold <= 1'b0;
      end else begin
         raw  <= raw_nxt;
         hold <= accept;
      end
   end
endmodule

// File: rtl/dual_integ_seq.sv
module dual_integ_seq
   import dual_integ_seq_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int UNIT   = 918,
   parameter int MULT0  = 11,
   parameter int MULT1  = 81,
   parameter int MULT2  = 322,
   parameter int OFFSET = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_wr,
   input  logic [7:0]       pwr_wdata,
   output logic [7:0]       pwr_rdata,
   input  logic             tim_wr,
   input  logic [7:0]       tim_wdata,
   output logic [7:0]       tim_rdata,
   input  logic             ch0_pulse,
   input  logic             ch1_pulse,
   output logic [CNT_W-1:0] data0,
   output logic [CNT_W-1:0] data1,
   output logic             eoc,
   output logic             gain_hi,
   output logic             powered_up,
   output logic             busy
);
   localparam int NCH = 2;

   logic [1:0]       pwr_bits, integ_code;
   logic             manual_bit, gain_bit;
   logic             count_en, restart, xfer;
   logic [NCH-1:0]   pulses;
   logic [CNT_W-1:0] folded [NCH];
   logic [CNT_W-1:0] result [NCH];

   dual_integ_seq_cfg u_cfg (
      .clk(clk), .rst_n(rst_n),
      .pwr_wr(pwr_wr), .pwr_wdata(pwr_wdata),
      .tim_wr(tim_wr), .tim_wdata(tim_wdata),
      .pwr_bits(pwr_bits), .integ_code(integ_code),
      .manual_bit(manual_bit), .gain_bit(gain_bit),
      .pwr_rdata(pwr_rdata), .tim_rdata(tim_rdata)
   );

   assign powered_up = (pwr_bits == PWR_ON);
   assign gain_hi    = gain_bit;

   dual_integ_seq_ctl #(
      .UNIT(UNIT), .MULT0(MULT0), .MULT1(MULT1), .MULT2(MULT2)
   ) u_ctl (
      .clk(clk), .rst_n(rst_n), .powered(powered_up),
      .integ_code(integ_code), .manual_bit(manual_bit),
      .count_en(count_en), .restart(restart), .xfer(xfer), .busy(busy)
   );

   assign pulses = {ch1_pulse, ch0_pulse};

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      dual_integ_seq_chan #(.CNT_W(CNT_W), .OFFSET(OFFSET), .HOLDOFF(1'b1)) u_cnt (
         .clk(clk), .rst_n(rst_n), .clear(restart), .en(count_en),
         .pulse(pulses[c]), .folded(folded[c])
      );
      always_ff @(posedge clk) begin
         if (!rst_n)    result[c] <= '0;
         else if (xfer) result[c] <= folded[c];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) eoc <= 1'b0;
      else        eoc <= xfer;
   end

   assign data0 = result[0];
   assign data1 = result[1];
endmodule

// File: rtl/dual_integ_seq_chk.sv
module dual_integ_seq_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwr_wr,
   input logic [7:0]       pwr_wdata,
   input logic [7:0]       pwr_rdata,
   input logic [CNT_W-1:0] data0,
   input logic [CNT_W-1:0] data1,
   input logic             eoc,
   input logic             powered_up,
   input logic             busy
);
   // R7
   eoc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eoc |=> !eoc);
   // R7
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !eoc |-> ($stable(data0) && $stable(data1)));
   // R11
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!powered_up && $past(!powered_up)) |-> !eoc);
   // R11
   off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!powered_up && $past(!powered_up)) |-> !busy);
   // R3
   eoc_from_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eoc |-> $past(busy));
   // R2
   pwr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pwr_wr) |-> (pwr_rdata == {6'b0, $past(pwr_wdata[1:0])}));
endmodule

bind dual_integ_seq dual_integ_seq_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .pwr_wr(pwr_wr), .pwr_wdata(pwr_wdata),
   .pwr_rdata(pwr_rdata), .data0(data0), .data1(data1), .eoc(eoc),
   .powered_up(powered_up), .busy(busy)
);

// File: tb/dual_integ_seq_test.sv
module dual_integ_seq_test;
   localparam int W    = 8;
   localparam int U    = 4;
   localparam int L0   = U * 11;
   localparam int L1   = U * 81;
   localparam int L2   = U * 322;
   localparam int MAXV = (1 << W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_wr = 1'b0, tim_wr = 1'b0;
   logic [7:0] pwr_wdata = '0, tim_wdata = '0;
   logic [7:0] pwr_rdata, tim_rdata;
   logic ch0 = 1'b0, ch1 = 1'b0;
   logic [W-1:0] data0, data1;
   logic eoc, gain_hi, powered_up, busy;

   int checks = 0, fails = 0;
   int cyc = 0, eoc_last = 0, eoc_gap = 0, eoc_cnt = 0;

   always #4 clk = ~clk;

   dual_integ_seq #(.CNT_W(W), .UNIT(U)) uut (
      .clk(clk), .rst_n(rst_n), .pwr_wr(pwr_wr), .pwr_wdata(pwr_wdata),
      .pwr_rdata(pwr_rdata), .tim_wr(tim_wr), .tim_wdata(tim_wdata),
      .tim_rdata(tim_rdata), .ch0_pulse(ch0), .ch1_pulse(ch1),
      .data0(data0), .data1(data1), .eoc(eoc), .gain_hi(gain_hi),
      .powered_up(powered_up), .busy(busy)
   );

   always @(posedge clk) cyc++;
   always @(negedge clk) if (eoc) begin
      eoc_gap  = cyc - eoc_last;
      eoc_last = cyc;
      eoc_cnt++;
   end

   function automatic int fold(input int n);
      if (n < 2) return 0;
      if (n - 2 > MAXV) return MAXV;
      return n - 2;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr_pwr(input logic [7:0] v);
      @(negedge clk); pwr_wr = 1'b1; pwr_wdata = v;
      @(negedge clk); pwr_wr = 1'b0;
   endtask

   task automatic wr_tim(input logic [7:0] v);
      @(negedge clk); tim_wr = 1'b1; tim_wdata = v;
      @(negedge clk); tim_wr = 1'b0;
   endtask

   task automatic wait_eoc(input int limit, output int waited);
      waited = 0;
      while (waited < limit) begin
         @(negedge clk); #1;
         waited++;
         if (eoc) return;
      end
      chk("eoc timeout", waited, -1);
   endtask

   task automatic burst(input int m, input int w, input int keep0);
      for (int k = 0; k < 30; k++) begin
         ch0 = (k % 3 == 0) && (k / 3 < m);
         ch1 = (k < w);
         @(negedge clk);
         if (keep0 >= 0 && k == 15) chk("R7 data0 held mid-window", data0, keep0);
      end
      ch0 = 1'b0; ch1 = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int w, cnt;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 powered", powered_up, 0);
      chk("R1 pwr_rdata", pwr_rdata, 8'h00);
      chk("R1 tim_rdata", tim_rdata, 8'h02);
      chk("R1 data0", data0, 0);
      chk("R1 data1", data1, 0);
      chk("R1 eoc/busy/gain", {eoc, busy, gain_hi}, 0);

      // R2 power up, R3/R6 longest preset with saturation
      ch0 = 1'b1; ch1 = 1'b1;
      wr_pwr(8'h03);
      chk("R2 powered", powered_up, 1);
      chk("R2 pwr_rdata", pwr_rdata, 8'h03);
      wait_eoc(L2 + 10, w);
      wait_eoc(L2 + 10, w);
      chk("R3 gap code10", eoc_gap, L2);
      chk("R6 data0 saturated", data0, MAXV);
      chk("R6 data1 saturated", data1, MAXV);

      // R8 change code mid-window
      wr_tim(8'h00);
      wait_eoc(L2 + 10, w);
      chk("R8 old length kept", eoc_gap, L2);
      wait_eoc(L0 + 10, w);
      chk("R3 gap code00", eoc_gap, L0);
      chk("R4 full scale code00", data0, fold(L0 / 2));
      chk("R4 full scale code00 ch1", data1, fold(L0 / 2));
      wr_tim(8'h01);
      wait_eoc(L0 + 10, w);
      chk("R8 old length kept 2", eoc_gap, L0);
      wait_eoc(L1 + 10, w);
      chk("R3 gap code01", eoc_gap, L1);
      chk("R4 full scale code01", data0, fold(L1 / 2));
      wr_tim(8'h00);
      wait_eoc(L1 + 10, w);
      wait_eoc(L0 + 10, w);
      chk("R3 gap code00 again", eoc_gap, L0);

      // R5/R4 bursts: m isolated pulses on ch0, 2m+1 solid cycles on ch1
      for (int m = 0; m < 10; m++) begin
         int prev0;
         prev0 = data0;
         burst(m, 2 * m + 1, prev0);
         wait_eoc(L0 + 10, w);
         chk("R5 isolated pulses ch0", data0, fold(m));
         chk("R4 solid run ch1", data1, fold(m + 1));
         chk("R3 gap during bursts", eoc_gap, L0);
      end

      // R10 manual bit ignored for preset code
      ch0 = 1'b1; ch1 = 1'b1;
      wr_tim(8'h08);
      wait_eoc(L0 + 10, w);
      wait_eoc(L0 + 10, w);
      chk("R10 gap with bit3 set", eoc_gap, L0);
      chk("R10 count with bit3 set", data0, fold(L0 / 2));

      // R12 gain bit
      wr_tim(8'h10);
      chk("R12 gain_hi", gain_hi, 1);
      chk("R12 tim_rdata", tim_rdata, 8'h10);
      wait_eoc(L0 + 10, w);
      wait_eoc(L0 + 10, w);
      chk("R12 gain does not scale", data0, fold(L0 / 2));
      wr_tim(8'hFF);
      chk("R12 tim_rdata reserved bits", tim_rdata, 8'h1B);

      // R9 manual mode
      wr_tim(8'h03);
      wait_eoc(L0 + 10, w);
      ch0 = 1'b0; ch1 = 1'b0;
      cnt = eoc_cnt;
      repeat (200) @(negedge clk);
      chk("R9 no eoc while waiting", eoc_cnt, cnt);
      chk("R9 idle while waiting", busy, 0);
      wr_tim(8'h0B);
      repeat (1500) @(negedge clk);
      chk("R9 manual runs past presets", eoc_cnt, cnt);
      chk("R9 busy in manual", busy, 1);
      burst(7, 9, -1);
      repeat (5) @(negedge clk);
      wr_tim(8'h03);
      wait_eoc(20, w);
      chk("R9 manual ch0", data0, fold(7));
      chk("R9 manual ch1", data1, fold(5));
      chk("R9 one eoc", eoc_cnt, cnt + 1);
      repeat (3) @(negedge clk);
      chk("R9 stopped", busy, 0);

      // R11 power-down hold
      ch0 = 1'b1; ch1 = 1'b1;
      wr_tim(8'h00);
      wait_eoc(L0 + 10, w);
      wait_eoc(L0 + 10, w);
      wr_pwr(8'h00);
      chk("R2 powered down", powered_up, 0);
      chk("R2 pwr_rdata 00", pwr_rdata, 8'h00);
      cnt = eoc_cnt;
      repeat (300) @(negedge clk);
      chk("R11 no eoc when off", eoc_cnt, cnt);
      chk("R11 data held", data0, fold(L0 / 2));
      chk("R11 idle when off", busy, 0);
      wr_pwr(8'hFF);
      chk("R2 pwr_rdata masked", pwr_rdata, 8'h03);
      wait_eoc(L0 + 10, w);
      chk("R11 fresh window after power-up", (w <= L0 + 3) ? 1 : 0, 1);
      chk("R11 full count after power-up", data0, fold(L0 / 2));
      wait_eoc(L0 + 10, w);
      chk("R3 gap after power-up", eoc_gap, L0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule